// File: doc/BRIEF.md
# Gated Sixteen-Bit Timer/Counter

This block is a 16-bit up-counter with a choice of count source: one tick every four system clocks, one tick on every system clock, or the rising edges of an external clock line. The chosen ticks pass through a power-of-two prescaler before they reach the counter. The external line can go through a two-stage synchronizer or through a single sampling flop. Either way, the counter ignores the external line until it has seen a falling edge since the timer was switched on.

A gate stage can hold the count still. The gate signal comes from one of four inputs and can be inverted. Two variants shape the count window. In toggle mode the window flips on each rising gate edge, so it spans one whole gate period. In single-pulse mode software arms a go bit, the counter measures exactly one gate pulse, and then the hardware drops the go bit and raises a gate interrupt flag. When the counter wraps, it raises an overflow flag. Both flags stay set until they are cleared.

All configuration arrives on plain level inputs. There is no data stream at the edge of the block, so it has no valid/ready handshake. Every output is registered or decoded from registers in the system clock domain.

Top module: `gtmr_top`

## Requirements
- R1: `cfg_clk_sel` picks the tick source: 2'b00 gives one tick every 4 system clocks, 2'b01 gives one tick per system clock, 2'b10 uses external clock rising edges, and 2'b11 gives no ticks.
- R2: With the external source selected, a rising edge counts only after a falling edge has been seen since `cfg_on` was raised. Dropping `cfg_on` disarms the source.
- R3: `cfg_presc` divides qualified ticks by 1, 2, 4 or 8 (codes 0 to 3). The prescaler is cleared by reset and by a load.
- R4: The count changes only while `cfg_on` is 1. A load (`load_en`) writes `load_val` and wins over a simultaneous increment.
- R5: An increment from 16'hFFFF gives 16'h0000 and sets `ovf_flag_o` on the same edge.
- R6: With `cfg_gate_en` at 1, counting runs only while the gate is active. The gate is the input chosen by `cfg_gate_src` (00 pin, 01 match, 10 comparator 1, 11 comparator 2), XORed with `cfg_gate_inv`. With `cfg_gate_en` at 0 the gate has no effect.
- R7: In toggle mode the count window flips on each rising edge of the gate, so it lasts one full gate period.
- R8: In single-pulse mode a `go_set` pulse raises `go_busy_o`. Counting then covers exactly the next whole gate pulse that begins after go is set. A pulse already in progress when go is set is not counted.
- R9: When that pulse ends, `go_busy_o` clears and `gate_irq_o` sets on the same edge.
- R10: With `cfg_sync` at 0 the external line is sampled through one flop rather than two. The same edges are counted in either mode.
- R11: `gate_level_o` is the gate level after inversion, registered, so it follows its input one clock later.
- R12: Both flags are sticky. `ovf_clr` and `gate_irq_clr` clear their flags and win over a set in the same cycle.
- R13: Reset clears the count, the prescaler, the toggle state, go and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_on | input | 1 | Timer enable |
| cfg_clk_sel | input | 2 | Tick source select |
| cfg_presc | input | 2 | Prescaler code, divide by 2^code |
| cfg_sync | input | 1 | 1: two-stage synchronizer on the external line |
| cfg_gate_en | input | 1 | Gate qualifies counting |
| cfg_gate_src | input | 2 | Gate source select |
| cfg_gate_inv | input | 1 | Invert the gate |
| cfg_gate_tog | input | 1 | Toggle mode |
| cfg_gate_single | input | 1 | Single-pulse mode |
| go_set | input | 1 | Arms single-pulse acquisition |
| ext_clk_i | input | 1 | External count clock |
| gate_pin_i | input | 1 | Gate source 0 |
| tmr_match_i | input | 1 | Gate source 1, another timer's period match |
| cmp1_i | input | 1 | Gate source 2 |
| cmp2_i | input | 1 | Gate source 3 |
| load_en | input | 1 | Write `load_val` into the count |
| load_val | input | 16 | Value to load |
| ovf_clr | input | 1 | Clear the overflow flag |
| gate_irq_clr | input | 1 | Clear the gate interrupt flag |
| count_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Overflow flag |
| gate_irq_o | output | 1 | Gate interrupt flag |
| go_busy_o | output | 1 | Go bit, which reads as done when 0 |
| gate_level_o | output | 1 | Registered gate level |

## Verification
The bench enables the external source both while the line is high and while it is low. A design that skipped the falling-edge arming would count one edge too many in the second case. It clears the prescaler by loading in the middle of a division and checks that no early carry appears. It also holds an overflow clear across a wrap, which a design giving set the priority would fail by leaving the flag high. In single-pulse mode it arms go in the middle of a pulse and sends a second pulse after completion. A design that counted partial pulses, or that did not clear go on completion, would end with a count other than the expected one.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  typedef enum logic [1:0] {
    CS_INSTR = 2'b00,
    CS_SYS   = 2'b01,
    CS_EXT   = 2'b10,
    CS_NONE  = 2'b11
  } clk_src_e;

  typedef enum logic [1:0] {
    GS_PIN   = 2'b00,
    GS_MATCH = 2'b01,
    GS_CMP1  = 2'b10,
    GS_CMP2  = 2'b11
  } gate_src_e;
endpackage

// File: rtl/gtmr_tick.sv
module gtmr_tick #(
  parameter int PS_W        = 2,
  parameter int INSTR_DIV   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            on,
  input  logic [1:0]      clk_sel,
  input  logic            sync_en,
  input  logic [PS_W-1:0] presc_sel,
  input  logic            ext_clk,
  input  logic            qual,
  input  logic            presc_clr,
  output logic            inc
);
  import gtmr_pkg::*;

  localparam int PH_W = $clog2(INSTR_DIV);
  localparam int PC_W = (1 << PS_W) - 1;

  logic [PH_W-1:0]        phase_q;
  logic [SYNC_STAGES-1:0] sy_q;
  logic                   samp_q, ext_prev_q, armed_q;
  logic                   ext_s, ext_rise, ext_fall;
  logic                   raw_tick, q_tick;
  logic [PC_W-1:0]        pcnt_q, pmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else if (phase_q == PH_W'(INSTR_DIV - 1)) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy_q[i] <= 1'b0;
      else if (i == 0) sy_q[i] <= ext_clk;
      else sy_q[i] <= sy_q[(i == 0) ? 0 : i - 1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q     <= 1'b0;
      ext_prev_q <= 1'b0;
    end else begin
      samp_q     <= ext_clk;
      ext_prev_q <= ext_s;
    end
  end

  assign ext_s    = sync_en ? sy_q[SYNC_STAGES-1] : samp_q;
  assign ext_rise = ext_s & ~ext_prev_q;
  assign ext_fall = ~ext_s & ext_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else if (!on || clk_sel != CS_EXT) armed_q <= 1'b0;
    else if (ext_fall) armed_q <= 1'b1;
  end

  always_comb begin
    unique case (clk_sel)
      CS_INSTR: raw_tick = (phase_q == PH_W'(INSTR_DIV - 1));
      CS_SYS:   raw_tick = 1'b1;
      CS_EXT:   raw_tick = ext_rise & armed_q;
      default:  raw_tick = 1'b0;
    endcase
  end

  assign q_tick = raw_tick & on & qual;
  assign pmask  = PC_W'((1 << presc_sel) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else if (presc_clr) pcnt_q <= '0;
    else if (q_tick) pcnt_q <= pcnt_q + 1'b1;
  end

  assign inc = q_tick && !presc_clr && ((pcnt_q & pmask) == pmask);

  // R2: an external tick needs a falling edge seen earlier while enabled
  p_ext_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == CS_EXT && inc) |-> armed_q);
  // R4: no tick reaches the counter while the timer is off
  p_off_no_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !on |-> !inc);
endmodule

// File: rtl/gtmr_gate.sv
module gtmr_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate_en,
  input  logic [1:0] src_sel,
  input  logic       inv,
  input  logic       tog_mode,
  input  logic       single_mode,
  input  logic       go_set,
  input  logic       pin,
  input  logic       match,
  input  logic       cmp1,
  input  logic       cmp2,
  input  logic       irq_clr,
  output logic       gate_ok,
  output logic       level,
  output logic       go,
  output logic       irq
);
  logic [3:0] srcs;
  logic       g_in, g_q, g_d, tog_q, win, win_q, go_q, sp_act_q, irq_q;
  logic       wrise, wfall, done;

  assign srcs = {cmp2, cmp1, match, pin};
  assign g_in = srcs[src_sel] ^ inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_q   <= 1'b0;
      g_d   <= 1'b0;
      win_q <= 1'b0;
    end else begin
      g_q   <= g_in;
      g_d   <= g_q;
      win_q <= win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else if (!tog_mode) tog_q <= 1'b0;
    else if (g_q & ~g_d) tog_q <= ~tog_q;
  end

  assign win   = tog_mode ? tog_q : g_q;
  assign wrise = win & ~win_q;
  assign wfall = ~win & win_q;
  assign done  = sp_act_q & wfall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q     <= 1'b0;
      sp_act_q <= 1'b0;
    end else if (!single_mode || !gate_en) begin
      go_q     <= 1'b0;
      sp_act_q <= 1'b0;
    end else if (done) begin
      go_q     <= 1'b0;
      sp_act_q <= 1'b0;
    end else begin
      if (go_set) go_q <= 1'b1;
      if (go_q && wrise) sp_act_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else if (irq_clr) irq_q <= 1'b0;
    else if (done && single_mode && gate_en) irq_q <= 1'b1;
  end

  always_comb begin
    if (!gate_en) gate_ok = 1'b1;
    else if (single_mode) gate_ok = win & (sp_act_q | (go_q & wrise));
    else gate_ok = win;
  end

  assign level = g_q;
  assign go    = go_q;
  assign irq   = irq_q;

  // R9: end of the measured pulse drops go and raises the flag
  p_done_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_act_q && wfall && single_mode && gate_en && !irq_clr) |=> (irq_q && !go_q));
  // R12: clear wins over set
  p_irq_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq_q);
  // R11: level follows the selected, inverted source one clock later
  p_level_lag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level == $past(g_in)));
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_on,
  input  logic [1:0]       cfg_clk_sel,
  input  logic [PS_W-1:0]  cfg_presc,
  input  logic             cfg_sync,
  input  logic             cfg_gate_en,
  input  logic [1:0]       cfg_gate_src,
  input  logic             cfg_gate_inv,
  input  logic             cfg_gate_tog,
  input  logic             cfg_gate_single,
  input  logic             go_set,
  input  logic             ext_clk_i,
  input  logic             gate_pin_i,
  input  logic             tmr_match_i,
  input  logic             cmp1_i,
  input  logic             cmp2_i,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ovf_clr,
  input  logic             gate_irq_clr,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             gate_irq_o,
  output logic             go_busy_o,
  output logic             gate_level_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             gate_ok, inc;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  gtmr_gate u_gate (
    .clk(clk), .rst_n(rst_n), .gate_en(cfg_gate_en), .src_sel(cfg_gate_src),
    .inv(cfg_gate_inv), .tog_mode(cfg_gate_tog), .single_mode(cfg_gate_single),
    .go_set(go_set), .pin(gate_pin_i), .match(tmr_match_i), .cmp1(cmp1_i),
    .cmp2(cmp2_i), .irq_clr(gate_irq_clr), .gate_ok(gate_ok),
    .level(gate_level_o), .go(go_busy_o), .irq(gate_irq_o)
  );

  gtmr_tick #(.PS_W(PS_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .on(cfg_on), .clk_sel(cfg_clk_sel),
    .sync_en(cfg_sync), .presc_sel(cfg_presc), .ext_clk(ext_clk_i),
    .qual(gate_ok), .presc_clr(load_en), .inc(inc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load_en) cnt_q <= load_val;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else if (ovf_clr) ovf_q <= 1'b0;
    else if (inc && !load_en && cnt_q == CNT_MAX) ovf_q <= 1'b1;
  end

  assign count_o    = cnt_q;
  assign ovf_flag_o = ovf_q;

  // R4: count holds while the timer is off and no load occurs
  p_hold_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_on && !load_en) |=> $stable(count_o));
  // R5: a wrap raises the overflow flag
  p_wrap_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load_en && !ovf_clr && count_o == CNT_MAX) |=> (ovf_flag_o && count_o == '0));
  // R12: overflow clear wins
  p_ovf_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |=> !ovf_flag_o);
  // R6: a closed plain gate freezes the count
  p_gate_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_gate_en && !cfg_gate_tog && !cfg_gate_single && !gate_level_o && !load_en)
      |=> $stable(count_o));
endmodule

// File: tb/gtmr_top_tb_top.sv
module gtmr_top_tb_top;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    string tag;
    int    kind;  // 0 count, 1 ovf, 2 gate irq, 3 go, 4 level
    int    exp;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_on = 0, cfg_sync = 1, cfg_gate_en = 0, cfg_gate_inv = 0;
  logic        cfg_gate_tog = 0, cfg_gate_single = 0, go_set = 0;
  logic [1:0]  cfg_clk_sel = 2'b01, cfg_presc = 2'b00, cfg_gate_src = 2'b00;
  logic        ext_clk_i = 0, gate_pin_i = 0, tmr_match_i = 0, cmp1_i = 0, cmp2_i = 0;
  logic        load_en = 0, ovf_clr = 0, gate_irq_clr = 0;
  logic [15:0] load_val = '0;
  logic [15:0] count_o;
  logic        ovf_flag_o, gate_irq_o, go_busy_o, gate_level_o;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gtmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_on(cfg_on), .cfg_clk_sel(cfg_clk_sel),
    .cfg_presc(cfg_presc), .cfg_sync(cfg_sync), .cfg_gate_en(cfg_gate_en),
    .cfg_gate_src(cfg_gate_src), .cfg_gate_inv(cfg_gate_inv),
    .cfg_gate_tog(cfg_gate_tog), .cfg_gate_single(cfg_gate_single),
    .go_set(go_set), .ext_clk_i(ext_clk_i), .gate_pin_i(gate_pin_i),
    .tmr_match_i(tmr_match_i), .cmp1_i(cmp1_i), .cmp2_i(cmp2_i),
    .load_en(load_en), .load_val(load_val), .ovf_clr(ovf_clr),
    .gate_irq_clr(gate_irq_clr), .count_o(count_o), .ovf_flag_o(ovf_flag_o),
    .gate_irq_o(gate_irq_o), .go_busy_o(go_busy_o), .gate_level_o(gate_level_o)
  );

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(input string tag, input int kind, input int exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic load(input logic [15:0] v);
    load_val = v; load_en = 1; run(1); load_en = 0;
  endtask

  task automatic count_for(input int n);
    cfg_on = 1; run(n); cfg_on = 0;
  endtask

  task automatic pulse(input int hi, input int lo);
    gate_pin_i = 1; run(hi); gate_pin_i = 0; run(lo);
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        int act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = int'(count_o);
          1: act = int'(ovf_flag_o);
          2: act = int'(gate_irq_o);
          3: act = int'(go_busy_o);
          default: act = int'(gate_level_o);
        endcase
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    run(3);
    rst_n = 1;
    run(1);
    expect_item("R13 count", 0, 0);
    expect_item("R13 ovf", 1, 0);
    expect_item("R13 girq", 2, 0);
    expect_item("R13 go", 3, 0);

    // R1 system clock source, R4 hold while off
    cfg_clk_sel = 2'b01; count_for(10);
    expect_item("R1 sys clock", 0, 10);
    run(3);
    expect_item("R4 hold off", 0, 10);

    // R1 instruction ticks
    load(0); cfg_clk_sel = 2'b00; count_for(20);
    expect_item("R1 instr div4", 0, 5);

    // R3 prescaler
    cfg_clk_sel = 2'b01;
    load(0); cfg_presc = 2'd2; count_for(20);
    expect_item("R3 div4", 0, 5);
    load(0); cfg_presc = 2'd3; count_for(24);
    expect_item("R3 div8", 0, 3);
    load(0); count_for(5); load(0); count_for(5);
    expect_item("R3 load clears prescaler", 0, 0);
    count_for(3);
    expect_item("R3 div8 after clear", 0, 1);
    cfg_presc = 2'd0;

    // R1 unused code
    load(0); cfg_clk_sel = 2'b11; count_for(10);
    expect_item("R1 no source", 0, 0);
    cfg_clk_sel = 2'b01;

    // R5 overflow, R12 sticky and clear priority
    load(16'hFFFE); count_for(3);
    expect_item("R5 wrap count", 0, 1);
    expect_item("R5 ovf set", 1, 1);
    run(5);
    expect_item("R12 ovf sticky", 1, 1);
    ovf_clr = 1; run(1); ovf_clr = 0;
    expect_item("R12 ovf cleared", 1, 0);
    load(16'hFFFF); ovf_clr = 1; cfg_on = 1; run(1); cfg_on = 0; ovf_clr = 0;
    expect_item("R12 clear beats set", 1, 0);
    expect_item("R5 wrapped to zero", 0, 0);

    // R4 load wins over increment
    load_val = 16'h1234; load_en = 1; cfg_on = 1; run(1); load_en = 0; run(2); cfg_on = 0;
    expect_item("R4 load priority", 0, 16'h1236);

    // R2 external source, synchronized
    load(0); cfg_clk_sel = 2'b10; cfg_sync = 1;
    ext_clk_i = 1; run(4); cfg_on = 1; run(3);
    for (int i = 0; i < 4; i++) begin ext_clk_i = 0; run(4); ext_clk_i = 1; run(4); end
    ext_clk_i = 0; run(6); cfg_on = 0;
    expect_item("R2 ext starting high", 0, 4);
    load(0); cfg_on = 1;
    for (int i = 0; i < 4; i++) begin ext_clk_i = 1; run(4); ext_clk_i = 0; run(4); end
    run(6); cfg_on = 0;
    expect_item("R2 first rise ignored", 0, 3);

    // R10 unsynchronized path counts the same edges
    load(0); cfg_sync = 0; ext_clk_i = 1; run(4); cfg_on = 1; run(3);
    for (int i = 0; i < 4; i++) begin ext_clk_i = 0; run(4); ext_clk_i = 1; run(4); end
    ext_clk_i = 0; run(6); cfg_on = 0;
    expect_item("R10 async ext", 0, 4);
    cfg_sync = 1; cfg_clk_sel = 2'b01;

    // R11 registered gate level
    cfg_gate_en = 1; cfg_gate_src = 2'b00; gate_pin_i = 0; run(2);
    gate_pin_i = 1;
    expect_item("R11 level lags", 4, 0);
    run(1);
    expect_item("R11 level follows", 4, 1);
    gate_pin_i = 0; run(2);

    // R6 gate from pin
    load(0); cfg_on = 1; run(5);
    expect_item("R6 gate closed", 0, 0);
    pulse(7, 5); cfg_on = 0;
    expect_item("R6 pin window", 0, 7);

    // R6 comparator 1 inverted
    cfg_gate_src = 2'b10; cfg_gate_inv = 1; cmp1_i = 1; gate_pin_i = 1; run(2);
    load(0); cfg_on = 1; run(4);
    cmp1_i = 0; run(6); cmp1_i = 1; run(4); cfg_on = 0;
    expect_item("R6 cmp1 inverted", 0, 6);
    gate_pin_i = 0; cfg_gate_inv = 0;

    // R6 comparator 2 and match source
    cfg_gate_src = 2'b11; run(2); load(0); cfg_on = 1;
    cmp2_i = 1; run(5); cmp2_i = 0; run(4); cfg_on = 0;
    expect_item("R6 cmp2", 0, 5);
    cfg_gate_src = 2'b01; run(2); load(0); cfg_on = 1;
    tmr_match_i = 1; run(3); tmr_match_i = 0; run(4); cfg_on = 0;
    expect_item("R6 match", 0, 3);

    // R6 gate disabled
    cfg_gate_src = 2'b00; cfg_gate_en = 0; load(0); count_for(4);
    expect_item("R6 gate ignored", 0, 4);

    // R7 toggle window spans one gate period
    cfg_gate_en = 1; cfg_gate_tog = 1; run(3); load(0); cfg_on = 1;
    pulse(3, 5); pulse(3, 10); cfg_on = 0;
    expect_item("R7 toggle period", 0, 8);
    cfg_gate_tog = 0; run(3);

    // R8 / R9 single pulse
    cfg_gate_single = 1; load(0); cfg_on = 1; run(2);
    expect_item("R8 go idle", 3, 0);
    go_set = 1; run(1); go_set = 0;
    expect_item("R8 go armed", 3, 1);
    pulse(6, 4);
    expect_item("R8 one pulse", 0, 6);
    expect_item("R9 go done", 3, 0);
    expect_item("R9 gate irq", 2, 1);
    pulse(5, 4);
    expect_item("R8 second pulse ignored", 0, 6);
    gate_irq_clr = 1; run(1); gate_irq_clr = 0;
    expect_item("R12 girq cleared", 2, 0);
    gate_pin_i = 1; run(3); go_set = 1; run(1); go_set = 0; run(3);
    gate_pin_i = 0; run(4);
    expect_item("R8 partial pulse skipped", 0, 6);
    expect_item("R8 go still armed", 3, 1);
    pulse(4, 4);
    expect_item("R8 next full pulse", 0, 10);
    expect_item("R9 go done again", 3, 0);
    cfg_on = 0;

    run(3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule